// File: doc/BRIEF.md
# Single-to-Half Precision Converter with Selectable Rounding

This block narrows an IEEE-754 binary32 operand to the binary16 value chosen by a per-operand rounding mode. Five modes can be selected: round toward positive infinity, toward negative infinity, toward zero, to nearest with ties to even, and to nearest with ties away from zero. The mode decides how the in-range fraction is rounded. It also decides the result when the magnitude is too large for binary16 or too small for its smallest subnormal, and how a subnormal result is rounded.

The datapath is combinational. A parameter adds one output register stage, which is on by default. An input strobe marks each operand, and an output strobe marks each result. Infinities keep their sign. NaNs are always returned quiet, so a signalling NaN whose payload sits only in the low fraction bits cannot turn into an infinity.

Top module: `sp_to_hp_cvt`

## Requirements
- R1: `rnd_mode` selects the rounding: 0 toward +inf, 1 toward -inf, 2 toward zero, 3 nearest-even, 4 nearest-away. The codes 5, 6 and 7 behave exactly like 3.
- R2: When the input biased exponent (bits 30:23) is 113 to 142, the result has exponent field (bits 14:10) equal to the input exponent minus 112, and the input fraction rounded to 10 bits under the selected mode.
- R3: If rounding carries out of the fraction, the carry raises the exponent. From input exponent 142 this can produce infinity (0x7C00 / 0xFC00).
- R4: When the input exponent is 101 to 112, the result is a subnormal (or the smallest normal after a carry). It equals the significand with the hidden 1, shifted right by 126 minus the exponent and rounded under the selected mode, with the sign in bit 15.
- R5: When the input exponent is 0 to 100, the result is a zero of the input sign. The exception is a nonzero input rounded away from zero by the mode (mode 0 with a positive input, or mode 1 with a negative input), which gives 0x0001 or 0x8001.
- R6: When the input exponent is 143 to 254, a mode that rounds away from zero or to nearest gives infinity of the input sign. A mode that truncates the magnitude gives the largest finite value, 0x7BFF or 0xFBFF.
- R7: An input infinity (exponent 255, fraction 0) gives the binary16 infinity of the same sign.
- R8: An input NaN gives sign unchanged, exponent field all ones, bit 9 set, and bits 8:0 equal to input fraction bits 21:13.
- R9: Mode 0 rounds positive inputs away from zero and negative inputs toward zero. Mode 1 does the opposite.
- R10: With the output register enabled, `out_valid` equals `in_valid` from one clock earlier, and `out_bits` holds the result for that operand. While reset is asserted, `out_valid` and `out_bits` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 32 | binary32 operand |
| rnd_mode | input | 3 | Rounding mode select |
| out_valid | output | 1 | Result strobe |
| out_bits | output | 16 | binary16 result |

## Verification
The bench covers, in every mode and with both signs, the exponent boundaries 100/101, 112/113 and 142/143, the largest finite value, and halfway fractions whose kept bit is even and whose kept bit is odd.

- A converter that confuses ties-to-even with ties-away gives a result one unit high on the even halfway cases.
- A wrong subnormal shift moves every result between 2^-25 and 2^-14.
- Missing carry propagation leaves 65520 finite instead of infinite.
- Skipping the quiet bit turns 0x7F800001 into infinity.

Random operands, weighted toward the subnormal and boundary exponents, are compared against an independent significand-and-quantum reference model.

// File: rtl/sp_to_hp_cvt.sv
module sp_to_hp_cvt #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_bits,
  input  logic [2:0]  rnd_mode,
  output logic        out_valid,
  output logic [15:0] out_bits
);

  localparam int EXP_W       = 8;
  localparam int FRAC_W      = 23;
  localparam int DROP_W      = 13;
  localparam int SIG_W       = FRAC_W + 3;
  localparam int SUB_LO      = 101;
  localparam int NRM_LO      = 113;
  localparam int OVF_LO      = 143;
  localparam int REBIAS      = 112;
  localparam int SHIFT_BASE  = 126;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [2:0]        md;
  logic              mag_up, mag_cut, near_even, near_away;

  assign sgn = in_bits[31];
  assign ex  = in_bits[30:23];
  assign fr  = in_bits[22:0];
  assign md  = (rnd_mode > 3'd4) ? 3'd3 : rnd_mode;

  assign mag_up    = (md == 3'd0 && !sgn) || (md == 3'd1 && sgn);
  assign mag_cut   = (md == 3'd2) || (md == 3'd0 && sgn) || (md == 3'd1 && !sgn);
  assign near_even = (md == 3'd3);
  assign near_away = (md == 3'd4);

  // normal path
  logic [DROP_W-1:0] nrm_k;
  logic [30:0]       nrm_sum;
  logic [EXP_W-1:0]  nrm_exp;
  logic [15:0]       nrm_res;

  always_comb begin
    if (mag_up)         nrm_k = 13'h1FFF;
    else if (mag_cut)   nrm_k = 13'h0000;
    else if (near_away) nrm_k = 13'h1000;
    else                nrm_k = 13'h0FFF + {12'd0, in_bits[DROP_W]};
  end

  assign nrm_sum = in_bits[30:0] + {18'd0, nrm_k};
  assign nrm_exp = nrm_sum[30:23] - EXP_W'(REBIAS);
  assign nrm_res = {sgn, nrm_exp[4:0], nrm_sum[22:13]};

  // subnormal path
  logic [4:0]       sub_sh;
  logic [SIG_W-1:0] sub_sig, sub_keep, sub_mask, sub_rem, sub_half;
  logic             sub_bump;
  logic [10:0]      sub_mag;
  logic [15:0]      sub_res;

  assign sub_sh   = 5'(EXP_W'(SHIFT_BASE) - ex);
  assign sub_sig  = {2'b00, 1'b1, fr};
  assign sub_keep = sub_sig >> sub_sh;
  assign sub_mask = (SIG_W'(1) << sub_sh) - SIG_W'(1);
  assign sub_rem  = sub_sig & sub_mask;
  assign sub_half = SIG_W'(1) << (sub_sh - 5'd1);

  always_comb begin
    if (mag_up)         sub_bump = (sub_rem != '0);
    else if (mag_cut)   sub_bump = 1'b0;
    else if (near_away) sub_bump = (sub_rem >= sub_half);
    else                sub_bump = (sub_rem > sub_half) || (sub_rem == sub_half && sub_keep[0]);
  end

  assign sub_mag = sub_keep[10:0] + {10'd0, sub_bump};
  assign sub_res = {sgn, 4'd0, sub_mag};

  // saturating and special cases
  logic [15:0] unf_res, ovf_res, spc_res, comb_res;

  assign unf_res = {sgn, 14'd0, mag_up && (in_bits[30:0] != '0)};
  assign ovf_res = {sgn, mag_cut ? 15'h7BFF : 15'h7C00};
  assign spc_res = {sgn, 5'h1F, (fr != '0) ? {1'b1, fr[21:13]} : 10'd0};

  always_comb begin
    if (ex == 8'hFF)                  comb_res = spc_res;
    else if (ex >= EXP_W'(OVF_LO))    comb_res = ovf_res;
    else if (ex >= EXP_W'(NRM_LO))    comb_res = nrm_res;
    else if (ex >= EXP_W'(SUB_LO))    comb_res = sub_res;
    else                              comb_res = unf_res;
  end

  logic unused_bits;
  assign unused_bits = ^{nrm_sum[12:0], nrm_exp[7:5], sub_keep[SIG_W-1:11], fr[12:0]};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_bits  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_bits <= comb_res;
        end
      end

      // R10
      lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

      // R6
      ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ex >= 8'd143 && ex != 8'hFF) |=>
          (out_bits[14:0] == 15'h7C00 || out_bits[14:0] == 15'h7BFF));

      // R5
      unf_tiny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ex <= 8'd100) |=> (out_bits[14:1] == 14'd0));

      // R8
      nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ex == 8'hFF && fr != '0) |=> (out_bits[14:9] == 6'h3F));

      // R7
      inf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ex == 8'hFF && fr == '0) |=>
          (out_bits == {$past(in_bits[31]), 15'h7C00}));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_bits  = comb_res;
    end
  endgenerate

endmodule

// File: tb/sp_to_hp_cvt_test.sv
module sp_to_hp_cvt_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = '0;
  logic [2:0]  rnd_mode = '0;
  logic        out_valid;
  logic [15:0] out_bits;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sp_to_hp_cvt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .out_bits(out_bits)
  );

  function automatic logic [15:0] ref_cvt(input logic [31:0] x, input logic [2:0] mr);
    logic [2:0] m;
    logic s;
    int e, e16, ee, sh;
    longint sig, q, r, unit, val;
    bit up, cut, inc;
    m = (mr > 3'd4) ? 3'd3 : mr;
    s = x[31];
    e = int'(x[30:23]);
    up  = (m == 0 && !s) || (m == 1 && s);
    cut = (m == 2) || (m == 0 && s) || (m == 1 && !s);
    if (e == 255) begin
      if (x[22:0] == 0) return {s, 15'h7C00};
      return {s, 5'h1F, 1'b1, x[21:13]};
    end
    if (e >= 143) return {s, cut ? 15'h7BFF : 15'h7C00};
    sig = (e == 0) ? longint'(x[22:0]) : (longint'(1) << 23) + longint'(x[22:0]);
    e16 = (e >= 113) ? e - 112 : 1;
    ee  = (e == 0) ? 1 : e;
    sh  = e16 - ee + 125;
    if (sh > 40) begin
      q = 0; r = sig; unit = longint'(1) << 40;
    end else begin
      q = sig >> sh; r = sig - (q << sh); unit = longint'(1) << sh;
    end
    if (up)          inc = (r != 0);
    else if (cut)    inc = 1'b0;
    else if (m == 4) inc = (2 * r >= unit);
    else             inc = (2 * r > unit) || (2 * r == unit && q[0]);
    val = (longint'(e16 - 1) << 10) + q + longint'(inc);
    return {s, val[14:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] x);
    int e;
    e = int'(x[30:23]);
    if (e == 255) return (x[22:0] != 0) ? "R8" : "R7";
    if (e >= 143) return "R6";
    if (e >= 113) return "R2";
    if (e >= 101) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tg, input logic [31:0] x, input logic [2:0] m,
                       input logic [15:0] exp_v);
    tests++;
    if (out_valid !== 1'b1 || out_bits !== exp_v) begin
      fails++;
      $display("FAIL %s in=%h mode=%0d got=%h/%b exp=%h/1", tg, x, m, out_bits, out_valid, exp_v);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [2:0] m,
                       input string tg, input logic [15:0] exp_v);
    @(negedge clk);
    in_valid = 1'b1; in_bits = x; rnd_mode = m;
    @(negedge clk);
    check(tg, x, m, exp_v);
    in_valid = 1'b0;
  endtask

  task automatic apply_ref(input logic [31:0] x, input logic [2:0] m);
    apply(x, m, tag_of(x), ref_cvt(x, m));
  endtask

  logic [31:0] corners [0:17];

  initial begin
    int seedv;
    seedv = $urandom(32'd20240611);
    corners[0]  = 32'h32000000; corners[1]  = 32'h327FFFFF;
    corners[2]  = 32'h32800000; corners[3]  = 32'h32FFFFFF;
    corners[4]  = 32'h38000000; corners[5]  = 32'h387FFFFF;
    corners[6]  = 32'h38800000; corners[7]  = 32'h46FFFFFF;
    corners[8]  = 32'h477FE000; corners[9]  = 32'h47800000;
    corners[10] = 32'h477FF000; corners[11] = 32'h3F801000;
    corners[12] = 32'h3F803000; corners[13] = 32'h38002000;
    corners[14] = 32'h38006000; corners[15] = 32'h33000000;
    corners[16] = 32'h00000001; corners[17] = 32'h7F800001;

    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || out_bits !== 16'h0000) begin
      fails++;
      $display("FAIL R10 reset got=%h/%b exp=0000/0", out_bits, out_valid);
    end
    rst_n = 1'b1;

    // R10: latency and strobe drop
    apply(32'h3F800000, 3'd3, "R10", 16'h3C00);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 strobe got=%b exp=0", out_valid);
    end

    // R9: sign-dependent directed rounding
    apply(32'h3F800001, 3'd0, "R9", 16'h3C01);
    apply(32'hBF800001, 3'd0, "R9", 16'hBC00);
    apply(32'hBF800001, 3'd1, "R9", 16'hBC01);
    apply(32'h3F800001, 3'd1, "R9", 16'h3C00);

    // R3: carry into exponent reaches infinity
    apply(32'h477FF000, 3'd3, "R3", 16'h7C00);
    apply(32'h477FE001, 3'd0, "R3", 16'h7C00);
    apply(32'h477FE001, 3'd2, "R3", 16'h7BFF);
    apply(32'h3F7FF000, 3'd4, "R3", 16'h3C00);

    // R1: reserved mode codes act as nearest-even
    for (int k = 5; k < 8; k++) begin
      apply(32'h3F803000, 3'(k), "R1", 16'h3C02);
      apply(32'h3F801000, 3'(k), "R1", 16'h3C00);
    end
    apply(32'h33000000, 3'd4, "R1", 16'h0001);
    apply(32'h33000000, 3'd3, "R1", 16'h0000);

    // R7 / R8 directed
    apply(32'hFF800000, 3'd2, "R7", 16'hFC00);
    apply(32'h7F800001, 3'd2, "R8", 16'h7E00);

    // R2 R4 R5 R6: corners in every mode and sign
    for (int m = 0; m < 5; m++)
      for (int i = 0; i < 18; i++) begin
        apply_ref(corners[i], 3'(m));
        apply_ref(corners[i] | 32'h80000000, 3'(m));
      end
    for (int m = 0; m < 5; m++) begin
      apply_ref(32'h00000000, 3'(m));
      apply_ref(32'h80000000, 3'(m));
    end

    // random operands weighted to boundary exponents
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] x;
      x = $urandom;
      if (n % 4 != 0) x[30:23] = 8'(95 + ($urandom % 55));
      apply_ref(x, 3'($urandom % 8));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule